// File: doc/BRIEF.md
# Quad-SPI Host Register and Data Buffer Front End

This block is the memory-mapped front end of a quad-SPI host controller. Software reaches it over a simple synchronous read/write port whose read data returns one cycle after the access. It holds the configuration, frame description and interrupt-mask registers. It also keeps two byte-wide buffers, one for bytes going out to the serial engine and one for bytes coming back. Each buffer has two access windows. One window moves a single byte. The other moves four packed bytes when the packed-access control flag is set.

The serial engine sits behind this block. It receives the frame fields, the lane and clock settings, and a one-cycle start strobe. It pops outgoing bytes one at a time and pushes incoming bytes one at a time. It reports transmit-done and receive-done pulses. Receive-done also marks the end of a frame and returns the block to ready. Done and buffer events collect into sticky status bits that software clears by writing 1. A single level interrupt is raised when any status bit that is enabled in the mask is set.

Top module: `qspi_regbank`

## Requirements
- R1: After reset the control, frame, upper-count and mask registers read 0, ready is 1, the interrupt is low, no start strobe is issued and both buffers are empty. The status word reads 0x98: TX-available (bit 3), RX-empty (bit 4) and ready (bit 7) are set.
- R2: Control at offset 0x00 keeps only bits 0 (enable), 1 (controller role), 10 (clock idle), 15:13 (lane mode), 16 (packed access) and 27:24 (clock rate), so writing all ones reads back 0x0F01E403. Bit 16 is mirrored in status bit 8, and the fields drive the engine outputs.
- R3: A write to the frame register (0x04) while ready is 1 and enable is 1 stores the word, clears ready and raises the start strobe for exactly one cycle. The engine sees total bytes = {upper register bits 31:16 at 0x50, frame bits 15:0}, command bytes = bits 24:16, multi-line = bit 25 and idle cycles = bits 29:26. A receive-done pulse sets ready again.
- R4: Frame and upper-count writes made while ready is 0 have no effect on the engine fields and give no start. A frame write while enable is 0 is also ignored.
- R5: A write to the byte TX window (0x44) queues data bits 7:0, unless the 16-entry buffer is full. The engine takes bytes in write order.
- R6: With packed access set, a write to the word TX window (0x4C) queues four bytes, bits 7:0 first and bits 31:24 last. It is refused unless four entries are free. With packed access clear, that window acts like the byte window.
- R7: A read of the byte RX window (0x40) returns the oldest byte in bits 7:0 and removes it. On an empty buffer it returns 0 and removes nothing.
- R8: With packed access set, a read of the word RX window (0x48) returns four bytes, oldest in bits 7:0, only when four are present. Otherwise it returns 0 and removes nothing.
- R9: Status bits 0 (TX done), 1 (RX done), 2 (RX available) and 3 (TX available) are sticky. Writing 1 to a bit at 0x10 clears it, and writing 0 has no effect. An event in the same cycle as the clear leaves the bit set.
- R10: RX available sets in every cycle the RX buffer is not empty. TX available sets in every cycle the TX buffer has room. Bit 4 (RX empty) and bit 5 (TX full) follow the buffer levels directly.
- R11: Mask bits 5:0 at 0x0C line up with status bits 5:0. The interrupt is high exactly when a set status bit in 5:0 has its mask bit set.
- R12: Read data appears on the read-data port in the cycle after the access and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq | output | 1 | Level interrupt |
| eng_start | output | 1 | One-cycle frame start strobe |
| eng_total_bytes | output | 32 | Total bytes of the frame |
| eng_cmd_bytes | output | 9 | Command bytes of the frame |
| eng_multi_line | output | 1 | Frame uses several lanes |
| eng_idle_cycles | output | 4 | Idle cycles before receive data |
| eng_flag_byte | output | 1 | Byte flag of the frame |
| eng_flag_word | output | 1 | Word flag of the frame |
| eng_enable | output | 1 | Core enable |
| eng_controller | output | 1 | Controller role select |
| eng_clk_idle | output | 1 | Serial clock idle level |
| eng_lane_mode | output | 3 | Lane mode and width |
| eng_clk_rate | output | 4 | Serial clock divider |
| eng_tx_pop | input | 1 | Engine takes one outgoing byte |
| eng_tx_byte | output | 8 | Oldest outgoing byte |
| eng_tx_empty | output | 1 | Outgoing buffer empty |
| eng_rx_push | input | 1 | Engine delivers one incoming byte |
| eng_rx_byte | input | 8 | Incoming byte |
| eng_rx_full | output | 1 | Incoming buffer full |
| eng_tx_done | input | 1 | Transmit-done pulse |
| eng_rx_done | input | 1 | Receive-done pulse, ends the frame |

## Verification
Two things can happen in the same cycle: software writes 1 to clear the TX-done status bit, and the engine raises its transmit-done pulse. The bench drives both in one clock. It then reads the status word and expects bit 0 still set, because a new event must never be lost. Reads in the cycles before and after show that a lone clear empties the bit and a lone write of 0 leaves it alone.

// File: rtl/qspi_regbank_pkg.sv
package qspi_regbank_pkg;

    localparam int BUS_W  = 32;
    localparam int WORD_B = BUS_W / 8;

    // register offsets
    localparam logic [7:0] OFF_CTRL  = 8'h00;
    localparam logic [7:0] OFF_FRAME = 8'h04;
    localparam logic [7:0] OFF_MASK  = 8'h0C;
    localparam logic [7:0] OFF_STAT  = 8'h10;
    localparam logic [7:0] OFF_RXB   = 8'h40;
    localparam logic [7:0] OFF_TXB   = 8'h44;
    localparam logic [7:0] OFF_RXW   = 8'h48;
    localparam logic [7:0] OFF_TXW   = 8'h4C;
    localparam logic [7:0] OFF_UPPER = 8'h50;

    // implemented control bits
    localparam logic [31:0] CTRL_KEEP = 32'h0F01_E403;

    localparam int C_ENABLE = 0;
    localparam int C_ROLE   = 1;
    localparam int C_CKIDLE = 10;
    localparam int C_PACKED = 16;

    // sticky status bit order (matches mask bits)
    localparam int S_TXDONE  = 0;
    localparam int S_RXDONE  = 1;
    localparam int S_RXAVAIL = 2;
    localparam int S_TXAVAIL = 3;
    localparam int N_STICKY  = 4;
    localparam int N_MASK    = 6;

endpackage

// File: rtl/qrb_fifo.sv
// Byte buffer with multi-byte push and multi-byte pop per cycle.
// DEPTH must be a power of two. The caller grants only what fits.
module qrb_fifo #(
    parameter int DEPTH = 16,
    parameter int IN_L  = 4,
    parameter int OUT_L = 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [$clog2(IN_L+1)-1:0]      push_n,
    input  logic [IN_L*8-1:0]              push_data,
    input  logic [$clog2(OUT_L+1)-1:0]     pop_n,
    output logic [OUT_L*8-1:0]             peek,
    output logic [$clog2(DEPTH+1)-1:0]     count
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [AW-1:0]         wptr;
        logic [AW-1:0]         rptr;
        logic [CW-1:0]         cnt;
    } fifo_t;

    fifo_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < IN_L; i++) begin
            if (i < int'(push_n)) begin
                st_d.mem[st_q.wptr + AW'(i)] = push_data[i*8 +: 8];
            end
        end
        st_d.wptr = st_q.wptr + AW'(push_n);
        st_d.rptr = st_q.rptr + AW'(pop_n);
        st_d.cnt  = st_q.cnt + CW'(push_n) - CW'(pop_n);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        for (int i = 0; i < OUT_L; i++) begin
            peek[i*8 +: 8] = st_q.mem[st_q.rptr + AW'(i)];
        end
    end

    assign count = st_q.cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH)); // R5

    AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (push_n != '0) |-> (CW'(push_n) <= CW'(DEPTH) - st_q.cnt)); // R6

    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_n != '0) |-> (CW'(pop_n) <= st_q.cnt)); // R8

endmodule

// File: rtl/qrb_status.sv
// Sticky event bits with write-1-to-clear, set wins; level interrupt.
module qrb_status
    import qspi_regbank_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_STICKY-1:0] clr_mask,
    input  logic [N_STICKY-1:0] evt_set,
    input  logic [1:0]          live_lvl,   // {tx full, rx empty}
    input  logic [N_MASK-1:0]   irq_mask,
    output logic [N_STICKY-1:0] sticky,
    output logic                irq
);

    typedef struct packed {
        logic [N_STICKY-1:0] bits;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < N_STICKY; b++) begin
            st_d.bits[b] = (st_q.bits[b] & ~clr_mask[b]) | evt_set[b];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sticky = st_q.bits;
    assign irq    = |(irq_mask & {live_lvl, st_q.bits});

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_set[S_TXDONE] |=> sticky[S_TXDONE]); // R9

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask[S_RXDONE] && !evt_set[S_RXDONE]) |=> !sticky[S_RXDONE]); // R9

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_mask != '0)); // R11

endmodule

// File: rtl/qspi_regbank.sv
module qspi_regbank
    import qspi_regbank_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        eng_start,
    output logic [31:0] eng_total_bytes,
    output logic [8:0]  eng_cmd_bytes,
    output logic        eng_multi_line,
    output logic [3:0]  eng_idle_cycles,
    output logic        eng_flag_byte,
    output logic        eng_flag_word,
    output logic        eng_enable,
    output logic        eng_controller,
    output logic        eng_clk_idle,
    output logic [2:0]  eng_lane_mode,
    output logic [3:0]  eng_clk_rate,
    input  logic        eng_tx_pop,
    output logic [7:0]  eng_tx_byte,
    output logic        eng_tx_empty,
    input  logic        eng_rx_push,
    input  logic [7:0]  eng_rx_byte,
    output logic        eng_rx_full,
    input  logic        eng_tx_done,
    input  logic        eng_rx_done
);

    localparam int CW  = $clog2(DEPTH+1);
    localparam int WNW = $clog2(WORD_B+1);

    typedef struct packed {
        logic [31:0]       ctrl;
        logic [31:0]       frames;
        logic [15:0]       upper;
        logic [N_MASK-1:0] mask;
        logic              ready;
        logic              start;
        logic [31:0]       rdata;
    } regs_t;

    localparam regs_t REGS_RST = '{ctrl: '0, frames: '0, upper: '0, mask: '0,
                                   ready: 1'b1, start: 1'b0, rdata: '0};

    regs_t rq_q, rq_d;

    // buffer plumbing
    logic [WNW-1:0]       tx_push_n;
    logic [BUS_W-1:0]     tx_push_data;
    logic                 tx_pop_n;
    logic [7:0]           tx_peek;
    logic [CW-1:0]        tx_cnt;
    logic                 rx_push_n;
    logic [WNW-1:0]       rx_pop_n;
    logic [BUS_W-1:0]     rx_peek;
    logic [CW-1:0]        rx_cnt;

    logic [N_STICKY-1:0]  clr_mask;
    logic [N_STICKY-1:0]  evt_set;
    logic [N_STICKY-1:0]  sticky;
    logic                 rx_empty, tx_full;
    logic                 acc_wr, acc_rd, packed_on;
    logic [CW-1:0]        tx_free;
    logic [31:0]          rx_word, stat_word;

    assign acc_wr    = bus_en & bus_we;
    assign acc_rd    = bus_en & ~bus_we;
    assign packed_on = rq_q.ctrl[C_PACKED];
    assign tx_free   = CW'(DEPTH) - tx_cnt;
    assign rx_empty  = (rx_cnt == '0);
    assign tx_full   = (tx_cnt == CW'(DEPTH));

    // outgoing buffer: bus writes, engine pops
    always_comb begin
        tx_push_n    = '0;
        tx_push_data = '0;
        if (acc_wr && (bus_addr == OFF_TXB || (bus_addr == OFF_TXW && !packed_on))) begin
            if (!tx_full) begin
                tx_push_n    = WNW'(1);
                tx_push_data = {24'b0, bus_wdata[7:0]};
            end
        end else if (acc_wr && bus_addr == OFF_TXW) begin
            if (tx_free >= CW'(WORD_B)) begin
                tx_push_n    = WNW'(WORD_B);
                tx_push_data = bus_wdata;
            end
        end
        tx_pop_n = eng_tx_pop && (tx_cnt != '0);
    end

    // incoming buffer: engine pushes, bus reads
    always_comb begin
        rx_push_n = eng_rx_push && (rx_cnt != CW'(DEPTH));
        rx_pop_n  = '0;
        rx_word   = '0;
        if (acc_rd && (bus_addr == OFF_RXB || (bus_addr == OFF_RXW && !packed_on))) begin
            if (!rx_empty) begin
                rx_pop_n = WNW'(1);
                rx_word  = {24'b0, rx_peek[7:0]};
            end
        end else if (acc_rd && bus_addr == OFF_RXW) begin
            if (rx_cnt >= CW'(WORD_B)) begin
                rx_pop_n = WNW'(WORD_B);
                rx_word  = rx_peek;
            end
        end
    end

    qrb_fifo #(.DEPTH(DEPTH), .IN_L(WORD_B), .OUT_L(1)) u_tx_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_n    (tx_push_n),
        .push_data (tx_push_data),
        .pop_n     (tx_pop_n),
        .peek      (tx_peek),
        .count     (tx_cnt)
    );

    qrb_fifo #(.DEPTH(DEPTH), .IN_L(1), .OUT_L(WORD_B)) u_rx_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_n    (rx_push_n),
        .push_data (eng_rx_byte),
        .pop_n     (rx_pop_n),
        .peek      (rx_peek),
        .count     (rx_cnt)
    );

    // status events
    always_comb begin
        clr_mask = (acc_wr && bus_addr == OFF_STAT) ? bus_wdata[N_STICKY-1:0] : '0;
        evt_set                = '0;
        evt_set[S_TXDONE]      = eng_tx_done;
        evt_set[S_RXDONE]      = eng_rx_done;
        evt_set[S_RXAVAIL]     = !rx_empty;
        evt_set[S_TXAVAIL]     = !tx_full;
    end

    qrb_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_mask (clr_mask),
        .evt_set  (evt_set),
        .live_lvl ({tx_full, rx_empty}),
        .irq_mask (rq_q.mask),
        .sticky   (sticky),
        .irq      (irq)
    );

    assign stat_word = {23'b0, packed_on, rq_q.ready, 1'b0, tx_full, rx_empty, sticky};

    // register bank next state
    always_comb begin
        rq_d       = rq_q;
        rq_d.start = 1'b0;
        if (eng_rx_done) begin
            rq_d.ready = 1'b1;
        end
        if (acc_wr) begin
            case (bus_addr)
                OFF_CTRL:  rq_d.ctrl = bus_wdata & CTRL_KEEP;
                OFF_MASK:  rq_d.mask = bus_wdata[N_MASK-1:0];
                OFF_FRAME: begin
                    if (rq_q.ready && rq_q.ctrl[C_ENABLE]) begin
                        rq_d.frames = bus_wdata;
                        rq_d.start  = 1'b1;
                        rq_d.ready  = 1'b0;
                    end
                end
                OFF_UPPER: begin
                    if (rq_q.ready) begin
                        rq_d.upper = bus_wdata[31:16];
                    end
                end
                default: ;
            endcase
        end
        if (acc_rd) begin
            case (bus_addr)
                OFF_CTRL:          rq_d.rdata = rq_q.ctrl;
                OFF_FRAME:         rq_d.rdata = rq_q.frames;
                OFF_MASK:          rq_d.rdata = {{(32-N_MASK){1'b0}}, rq_q.mask};
                OFF_STAT:          rq_d.rdata = stat_word;
                OFF_UPPER:         rq_d.rdata = {rq_q.upper, 16'b0};
                OFF_RXB, OFF_RXW:  rq_d.rdata = rx_word;
                default:           rq_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_q <= REGS_RST;
        end else begin
            rq_q <= rq_d;
        end
    end

    assign bus_rdata       = rq_q.rdata;
    assign eng_start       = rq_q.start;
    assign eng_total_bytes = {rq_q.upper, rq_q.frames[15:0]};
    assign eng_cmd_bytes   = rq_q.frames[24:16];
    assign eng_multi_line  = rq_q.frames[25];
    assign eng_idle_cycles = rq_q.frames[29:26];
    assign eng_flag_byte   = rq_q.frames[30];
    assign eng_flag_word   = rq_q.frames[31];
    assign eng_enable      = rq_q.ctrl[C_ENABLE];
    assign eng_controller  = rq_q.ctrl[C_ROLE];
    assign eng_clk_idle    = rq_q.ctrl[C_CKIDLE];
    assign eng_lane_mode   = rq_q.ctrl[15:13];
    assign eng_clk_rate    = rq_q.ctrl[27:24];
    assign eng_tx_byte     = tx_peek;
    assign eng_tx_empty    = (tx_cnt == '0);
    assign eng_rx_full     = (rx_cnt == CW'(DEPTH));

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start); // R3

    AST_START_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !rq_q.ready); // R3

    AST_BUSY_FRAME_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rq_q.ready |=> ($stable(eng_total_bytes) && $stable(eng_cmd_bytes) && !eng_start)); // R4

    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_enable |=> !eng_start); // R4

endmodule

// File: tb/qspi_regbank_test.sv
module qspi_regbank_test;

    localparam logic [7:0] A_CTRL = 8'h00, A_FRAME = 8'h04, A_MASK = 8'h0C,
                           A_STAT = 8'h10, A_RXB = 8'h40, A_TXB = 8'h44,
                           A_RXW = 8'h48, A_TXW = 8'h4C, A_UP = 8'h50;

    typedef struct packed {
        logic        we;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0,          4'd2},  // R2
        '{1'b0, 8'h00, 32'h0,         32'h0F01_E403,  4'd2},  // R2 mask of kept bits
        '{1'b1, 8'h00, 32'h0001_0003, 32'h0,          4'd2},  // R2
        '{1'b0, 8'h00, 32'h0,         32'h0001_0003,  4'd2},  // R2
        '{1'b1, 8'h0C, 32'hFFFF_FFC0, 32'h0,          4'd11}, // R11
        '{1'b0, 8'h0C, 32'h0,         32'h0,          4'd11}, // R11
        '{1'b1, 8'h4C, 32'h4433_2211, 32'h0,          4'd6},  // R6
        '{1'b1, 8'h4C, 32'h8877_6655, 32'h0,          4'd6},  // R6
        '{1'b1, 8'h44, 32'h0000_AB99, 32'h0,          4'd5},  // R5
        '{1'b0, 8'h10, 32'h0,         32'h0000_0198,  4'd10}, // R10
        '{1'b1, 8'h50, 32'h0001_ABCD, 32'h0,          4'd3},  // R3
        '{1'b0, 8'h50, 32'h0,         32'h0001_0000,  4'd3}   // R3
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, eng_start;
    logic [31:0] eng_total_bytes;
    logic [8:0]  eng_cmd_bytes;
    logic        eng_multi_line;
    logic [3:0]  eng_idle_cycles;
    logic        eng_flag_byte, eng_flag_word, eng_enable, eng_controller, eng_clk_idle;
    logic [2:0]  eng_lane_mode;
    logic [3:0]  eng_clk_rate;
    logic        eng_tx_pop = 1'b0;
    logic [7:0]  eng_tx_byte;
    logic        eng_tx_empty;
    logic        eng_rx_push = 1'b0;
    logic [7:0]  eng_rx_byte = '0;
    logic        eng_rx_full;
    logic        eng_tx_done = 1'b0, eng_rx_done = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    qspi_regbank uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .eng_start(eng_start), .eng_total_bytes(eng_total_bytes),
        .eng_cmd_bytes(eng_cmd_bytes), .eng_multi_line(eng_multi_line),
        .eng_idle_cycles(eng_idle_cycles), .eng_flag_byte(eng_flag_byte),
        .eng_flag_word(eng_flag_word), .eng_enable(eng_enable),
        .eng_controller(eng_controller), .eng_clk_idle(eng_clk_idle),
        .eng_lane_mode(eng_lane_mode), .eng_clk_rate(eng_clk_rate),
        .eng_tx_pop(eng_tx_pop), .eng_tx_byte(eng_tx_byte), .eng_tx_empty(eng_tx_empty),
        .eng_rx_push(eng_rx_push), .eng_rx_byte(eng_rx_byte), .eng_rx_full(eng_rx_full),
        .eng_tx_done(eng_tx_done), .eng_rx_done(eng_rx_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic pop_expect(input string req, input logic [7:0] exp);
        chk(req, {24'b0, eng_tx_byte}, {24'b0, exp});
        eng_tx_pop = 1'b1;
        @(negedge clk);
        eng_tx_pop = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] b);
        eng_rx_push = 1'b1; eng_rx_byte = b;
        @(negedge clk);
        eng_rx_push = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk("R1 start", {31'b0, eng_start}, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 tx empty", {31'b0, eng_tx_empty}, 32'h1);
        bus_read(A_CTRL);  chk("R1 ctrl", bus_rdata, 32'h0);
        bus_read(A_STAT);  chk("R1 status", bus_rdata, 32'h0000_0098);
        bus_read(A_FRAME); chk("R1 frame", bus_rdata, 32'h0);
        chk("R12 rdata held", bus_rdata, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].we) begin
                bus_write(VECS[i].addr, VECS[i].data);
            end else begin
                bus_read(VECS[i].addr);
                chk($sformatf("R%0d table[%0d]", VECS[i].req, i), bus_rdata, VECS[i].exp);
            end
        end
        chk("R2 packed mirror lane", {29'b0, eng_lane_mode}, 32'h0);
        chk("R2 enable out", {31'b0, eng_enable}, 32'h1);

        // R5 R6 engine order, little-endian lanes
        for (int k = 1; k <= 8; k++) pop_expect("R6 order", 8'(k * 8'h11));
        pop_expect("R5 byte", 8'h99);
        chk("R5 drained", {31'b0, eng_tx_empty}, 32'h1);

        // R6 fill to 16, refusals
        for (int k = 0; k < 4; k++)
            bus_write(A_TXW, {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
        bus_read(A_STAT); chk("R10 tx full", bus_rdata & 32'h20, 32'h20);
        bus_write(A_TXW, 32'hAAAA_AAAA);
        bus_write(A_TXB, 32'h0000_00CC);
        pop_expect("R6 head", 8'h00);
        bus_write(A_TXW, 32'hBBBB_BBBB);   // one free: refused
        bus_write(A_TXB, 32'h0000_00CC);   // accepted
        for (int k = 1; k < 16; k++) pop_expect("R6 full refuse", 8'(k));
        pop_expect("R5 last", 8'hCC);
        chk("R6 no extra", {31'b0, eng_tx_empty}, 32'h1);

        // R6 word window without packed access moves one byte
        bus_write(A_CTRL, 32'h0000_0003);
        bus_write(A_TXW, 32'h1234_56EE);
        pop_expect("R6 unpacked", 8'hEE);
        chk("R6 unpacked single", {31'b0, eng_tx_empty}, 32'h1);
        bus_write(A_CTRL, 32'h0001_0003);

        // R7 R8 receive windows
        for (int k = 0; k < 5; k++) rx_push(8'hA0 + 8'(k));
        bus_read(A_STAT); chk("R10 rx avail", bus_rdata & 32'h14, 32'h04);
        bus_read(A_RXW);  chk("R8 word pop", bus_rdata, 32'hA3A2_A1A0);
        bus_read(A_RXW);  chk("R8 short word", bus_rdata, 32'h0);
        bus_read(A_RXB);  chk("R7 byte pop", bus_rdata, 32'h0000_00A4);
        bus_read(A_RXB);  chk("R7 empty read", bus_rdata, 32'h0);
        bus_write(A_STAT, 32'h0000_0004);
        bus_read(A_STAT); chk("R10 rx avail cleared", bus_rdata & 32'h14, 32'h10);

        // R3 frame launch
        bus_write(A_FRAME, 32'h0E04_0010);
        chk("R3 start high", {31'b0, eng_start}, 32'h1);
        chk("R3 total", eng_total_bytes, 32'h0001_0010);
        chk("R3 cmd", {23'b0, eng_cmd_bytes}, 32'h4);
        chk("R3 idle", {28'b0, eng_idle_cycles}, 32'h3);
        chk("R3 multi", {31'b0, eng_multi_line}, 32'h1);
        @(negedge clk);
        chk("R3 start one cycle", {31'b0, eng_start}, 32'h0);

        // R4 busy writes ignored
        bus_write(A_FRAME, 32'hFFFF_FFFF);
        chk("R4 no start busy", {31'b0, eng_start}, 32'h0);
        bus_write(A_UP, 32'h0005_0000);
        chk("R4 total held", eng_total_bytes, 32'h0001_0010);
        bus_read(A_STAT); chk("R3 busy", bus_rdata & 32'h80, 32'h0);
        eng_rx_done = 1'b1; @(negedge clk); eng_rx_done = 1'b0;
        bus_read(A_STAT); chk("R3 ready again", bus_rdata & 32'h82, 32'h82);

        // R4 disabled
        bus_write(A_CTRL, 32'h0001_0002);
        bus_write(A_FRAME, 32'h0000_0022);
        chk("R4 no start disabled", {31'b0, eng_start}, 32'h0);
        bus_read(A_FRAME); chk("R4 frame held", bus_rdata, 32'h0E04_0010);
        bus_write(A_CTRL, 32'h0001_0003);

        // R9 write-1-to-clear and the same-cycle conflict
        bus_write(A_STAT, 32'h0000_0003);
        bus_read(A_STAT); chk("R9 cleared", bus_rdata & 32'h3, 32'h0);
        eng_tx_done = 1'b1; @(negedge clk); eng_tx_done = 1'b0;
        bus_read(A_STAT); chk("R9 event sets", bus_rdata & 32'h1, 32'h1);
        bus_write(A_STAT, 32'h0);
        bus_read(A_STAT); chk("R9 zero no effect", bus_rdata & 32'h1, 32'h1);
        bus_write(A_STAT, 32'h1);
        bus_read(A_STAT); chk("R9 one clears", bus_rdata & 32'h1, 32'h0);
        eng_tx_done = 1'b1;
        bus_write(A_STAT, 32'h1);
        eng_tx_done = 1'b0;
        bus_read(A_STAT); chk("R9 set wins", bus_rdata & 32'h1, 32'h1);

        // R11 interrupt masking
        bus_write(A_MASK, 32'h01); chk("R11 txdone irq", {31'b0, irq}, 32'h1);
        bus_write(A_STAT, 32'h01); chk("R11 irq drops", {31'b0, irq}, 32'h0);
        bus_write(A_MASK, 32'h08); chk("R11 txavail irq", {31'b0, irq}, 32'h1);
        bus_write(A_MASK, 32'h10); chk("R11 rxempty irq", {31'b0, irq}, 32'h1);
        bus_write(A_MASK, 32'h00); chk("R11 masked", {31'b0, irq}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule